// File: doc/BRIEF.md
# PASID Command and Response Unit

This block lets software obtain and return process address space identifiers through a small register window. Software writes an opcode, and for a release also an identifier, into a command register. It then polls a response register until its in-progress flag drops. The response then holds a two-bit status code and, after a successful allocation, the granted identifier.

Behind the registers sits a bitmap pool of `NUM_IDS` entries. The pool scans `SCAN_LANES` entries per cycle and grants the lowest free identifier. Identifier 0 is never granted. A read-only capability register reports whether allocation is offered. When it is not, the command register refuses every write.

Top module: `pasid_vcmd_unit`

## Requirements
- R1: The capability register at offset 0xE00 reads bit 0 = `ALLOC_SUPPORTED` with all other bits 0. Writes to it have no effect.
- R2: The response register at 0xE20 holds the in-progress flag in bit 0, the status in bits 2:1 (0 success, 1 unknown opcode, 2 no identifier or bad release) and the result in bits 27:8; all other bits read 0. It reads 0 after reset, and writes to it have no effect.
- R3: When a command is accepted, the response reads exactly 1 (busy, status 0, result 0) in the cycle after the write.
- R4: Opcode 0 (bits 7:0 of the command value) is a null command. It completes one cycle after acceptance with status 0 and result 0.
- R5: Opcode 1 grants the lowest free identifier in 1..NUM_IDS-1. It returns status 0 with the identifier in bits 27:8, and the flag stays set only while the pool scan runs.
- R6: Opcode 1 with every identifier 1..NUM_IDS-1 in use returns status 2 and result 0.
- R7: Opcode 2 releases the identifier in bits 27:8 of the command value, ignoring bits 31:28. Releasing an identifier that is in use returns status 0, and a later allocation can grant that identifier again.
- R8: Releasing identifier 0, an identifier of NUM_IDS or above, or an identifier that is not in use returns status 2 and leaves the pool unchanged.
- R9: Any opcode from 3 to 255 returns status 1 with result 0.
- R10: A command write while the in-progress flag is set is ignored. The command register keeps its value and the pool is unchanged.
- R11: With `ALLOC_SUPPORTED` = 0, command writes are ignored. The command and response registers stay 0.
- R12: A 32-bit write at 0xE14 is a command write under the same acceptance rules. Its 32-bit value is decoded as the command and stored in bits 63:32 of the command register, which read back at 0xE14 in bits 31:0.
- R13: The command register reads back at 0xE10 as 64 bits. A 32-bit write there changes only bits 31:0, and a 64-bit write changes all bits.
- R14: Reset empties the pool, so the first allocation after reset grants identifier 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Register byte offset for reads and writes |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wide | input | 1 | 1 for a 64-bit access, 0 for a 32-bit access |
| reg_wdata | input | 64 | Write data; bits 31:0 only for a 32-bit access |
| reg_rdata | output | 64 | Combinational read data for reg_addr |

## Verification
A wrong bit in the pool shows at the next allocation that reaches its scan window. The symptom is a duplicate grant, a skipped identifier, or status 2 too early or too late. Release checks make a stale bit visible within one command. A stuck control state shows as the in-progress flag not dropping within the scan length, or as a later command being refused. Filling the pool completely and draining parts of it puts every scan window and the no-free case in front of the response port.

// File: rtl/pasid_vcmd_pkg.sv
package pasid_vcmd_pkg;

   localparam int unsigned VC_ID_W = 20;

   localparam logic [11:0] OFS_CAP    = 12'hE00;
   localparam logic [11:0] OFS_CMD_LO = 12'hE10;
   localparam logic [11:0] OFS_CMD_HI = 12'hE14;
   localparam logic [11:0] OFS_RSP_LO = 12'hE20;
   localparam logic [11:0] OFS_RSP_HI = 12'hE24;

   localparam logic [7:0] OP_NULL  = 8'd0;
   localparam logic [7:0] OP_ALLOC = 8'd1;
   localparam logic [7:0] OP_FREE  = 8'd2;

   typedef enum logic [1:0] {
      ST_OK     = 2'd0,
      ST_BADCMD = 2'd1,
      ST_NORES  = 2'd2
   } vc_status_e;

   typedef enum logic {
      FSM_IDLE = 1'b0,
      FSM_EXEC = 1'b1
   } vc_fsm_e;

   function automatic logic [63:0] mk_rsp(input logic busy, input vc_status_e st,
                                          input logic [VC_ID_W-1:0] res);
      return {36'd0, res, 5'd0, st, busy};
   endfunction

endpackage

// File: rtl/pasid_lowest_pick.sv
module pasid_lowest_pick #(
   parameter int unsigned W = 16,
   localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      any = |req;
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req[i]) idx = i[IDX_W-1:0];
      end
   end
endmodule

// File: rtl/pasid_id_pool.sv
module pasid_id_pool
   import pasid_vcmd_pkg::*;
#(
   parameter int unsigned NUM_IDS    = 64,
   parameter int unsigned SCAN_LANES = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scan_restart,
   input  logic               scan_step,
   input  logic               free_vld,
   input  logic [VC_ID_W-1:0] free_id,
   output logic               scan_hit,
   output logic               scan_last,
   output logic [VC_ID_W-1:0] hit_id,
   output logic               free_ok
);
   localparam int unsigned NUM_CHUNKS = NUM_IDS / SCAN_LANES;
   localparam int unsigned CHK_W      = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1;
   localparam int unsigned LANE_W     = $clog2(SCAN_LANES);
   localparam int unsigned POOL_W     = $clog2(NUM_IDS);

   if (NUM_IDS < 2 || NUM_IDS > (1 << VC_ID_W)) begin : g_bad_ids
      $error("pasid_id_pool: NUM_IDS out of range");
   end
   if ((NUM_IDS & (NUM_IDS - 1)) != 0) begin : g_bad_ids_pow2
      $error("pasid_id_pool: NUM_IDS must be a power of two");
   end
   if (SCAN_LANES < 2 || (SCAN_LANES & (SCAN_LANES - 1)) != 0) begin : g_bad_lanes
      $error("pasid_id_pool: SCAN_LANES must be a power of two of at least 2");
   end
   if (SCAN_LANES > NUM_IDS) begin : g_bad_ratio
      $error("pasid_id_pool: SCAN_LANES exceeds NUM_IDS");
   end

   logic [NUM_IDS-1:0]    used_q;
   logic [CHK_W-1:0]      chunk_q;
   logic [SCAN_LANES-1:0] window;
   logic [SCAN_LANES-1:0] zero_mask;
   logic [SCAN_LANES-1:0] avail;
   logic [LANE_W-1:0]     lane_idx;
   logic [POOL_W-1:0]     hit_idx;
   logic [POOL_W-1:0]     free_idx;

   if (NUM_CHUNKS == 1) begin : g_single
      assign chunk_q   = '0;
      assign window    = used_q;
      assign scan_last = 1'b1;
      assign hit_id    = VC_ID_W'(lane_idx);
   end else begin : g_multi
      always_ff @(posedge clk) begin
         if (!rst_n || scan_restart) begin
            chunk_q <= '0;
         end else if (scan_step && !scan_hit && !scan_last) begin
            chunk_q <= chunk_q + 1'b1;
         end
      end
      assign window    = used_q[chunk_q*SCAN_LANES +: SCAN_LANES];
      assign scan_last = (chunk_q == CHK_W'(NUM_CHUNKS - 1));
      assign hit_id    = VC_ID_W'({chunk_q, lane_idx});
   end

   assign zero_mask = {{(SCAN_LANES-1){1'b0}}, (chunk_q == '0)};
   assign avail     = ~window & ~zero_mask;

   pasid_lowest_pick #(.W(SCAN_LANES)) u_pick (
      .req (avail),
      .any (scan_hit),
      .idx (lane_idx)
   );

   assign hit_idx  = hit_id[POOL_W-1:0];
   assign free_idx = free_id[POOL_W-1:0];
   assign free_ok  = (free_id != '0) && ({12'd0, free_id} < 32'(NUM_IDS)) && used_q[free_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         used_q <= '0;
      end else begin
         if (scan_step && scan_hit) used_q[hit_idx] <= 1'b1;
         if (free_vld && free_ok)   used_q[free_idx] <= 1'b0;
      end
   end

   // R5: a grant names an identifier that was free and is not zero
   p_grant_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_step && scan_hit) |-> (hit_id != '0 && !used_q[hit_idx]));
   // R5: a granted identifier is marked in use afterwards
   p_grant_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_step && scan_hit) |=> used_q[$past(hit_idx)]);
   // R7: an accepted release clears the identifier
   p_free_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (free_vld && free_ok) |=> !used_q[$past(free_idx)]);
   // R8: identifier 0 never enters the pool
   p_id0_never_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !used_q[0]);
endmodule

// File: rtl/pasid_vcmd_ctrl.sv
module pasid_vcmd_ctrl
   import pasid_vcmd_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cap_on,
   input  logic               cmd_wr,
   input  logic [27:0]        cmd_val,
   output logic               accept,
   output logic [63:0]        rsp_q,
   output logic               scan_restart,
   output logic               scan_step,
   output logic               free_vld,
   output logic [VC_ID_W-1:0] free_id,
   input  logic               scan_hit,
   input  logic               scan_last,
   input  logic [VC_ID_W-1:0] hit_id,
   input  logic               free_ok
);
   vc_fsm_e            state_q;
   logic [7:0]         op_q;
   logic [VC_ID_W-1:0] id_q;

   assign accept       = cmd_wr && cap_on && (state_q == FSM_IDLE);
   assign scan_restart = accept;
   assign scan_step    = (state_q == FSM_EXEC) && (op_q == OP_ALLOC);
   assign free_vld     = (state_q == FSM_EXEC) && (op_q == OP_FREE);
   assign free_id      = id_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FSM_IDLE;
         op_q    <= '0;
         id_q    <= '0;
         rsp_q   <= '0;
      end else begin
         case (state_q)
            FSM_IDLE: begin
               if (accept) begin
                  op_q    <= cmd_val[7:0];
                  id_q    <= cmd_val[27:8];
                  rsp_q   <= mk_rsp(1'b1, ST_OK, '0);
                  state_q <= FSM_EXEC;
               end
            end
            default: begin
               case (op_q)
                  OP_NULL: begin
                     rsp_q   <= mk_rsp(1'b0, ST_OK, '0);
                     state_q <= FSM_IDLE;
                  end
                  OP_FREE: begin
                     rsp_q   <= mk_rsp(1'b0, free_ok ? ST_OK : ST_NORES, '0);
                     state_q <= FSM_IDLE;
                  end
                  OP_ALLOC: begin
                     if (scan_hit) begin
                        rsp_q   <= mk_rsp(1'b0, ST_OK, hit_id);
                        state_q <= FSM_IDLE;
                     end else if (scan_last) begin
                        rsp_q   <= mk_rsp(1'b0, ST_NORES, '0);
                        state_q <= FSM_IDLE;
                     end
                  end
                  default: begin
                     rsp_q   <= mk_rsp(1'b0, ST_BADCMD, '0);
                     state_q <= FSM_IDLE;
                  end
               endcase
            end
         endcase
      end
   end

   // R3: an accepted command shows busy with clean status and result
   p_accept_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (rsp_q == 64'd1));
   // R4: commands other than allocation finish after one busy cycle
   p_quick_ops_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cmd_val[7:0] != OP_ALLOC) |=> ##1 !rsp_q[0]);
   // R2: status code 3 never appears
   p_status_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_q[2:1] != 2'b11);
   // R10: nothing is accepted while busy
   p_no_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_q[0] |-> !accept);
   // R11: without the capability the response stays clear
   p_nocap_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_on |-> (rsp_q == 64'd0));
endmodule

// File: rtl/pasid_vcmd_unit.sv
module pasid_vcmd_unit
   import pasid_vcmd_pkg::*;
#(
   parameter int unsigned NUM_IDS         = 64,
   parameter int unsigned SCAN_LANES      = 16,
   parameter bit          ALLOC_SUPPORTED = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [11:0] reg_addr,
   input  logic        reg_wr,
   input  logic        reg_wide,
   input  logic [63:0] reg_wdata,
   output logic [63:0] reg_rdata
);
   localparam logic [63:0] CAP_VAL = {63'd0, ALLOC_SUPPORTED};

   logic [63:0]        cmd_q;
   logic [63:0]        rsp_q;
   logic               wr_lo, wr_hi, cmd_wr, accept;
   logic               scan_restart, scan_step, scan_hit, scan_last;
   logic               free_vld, free_ok;
   logic [VC_ID_W-1:0] free_id, hit_id;

   assign wr_lo  = reg_wr && (reg_addr == OFS_CMD_LO);
   assign wr_hi  = reg_wr && (reg_addr == OFS_CMD_HI) && !reg_wide;
   assign cmd_wr = wr_lo || wr_hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (accept) begin
         if (wr_hi)         cmd_q[63:32] <= reg_wdata[31:0];
         else if (reg_wide) cmd_q        <= reg_wdata;
         else               cmd_q[31:0]  <= reg_wdata[31:0];
      end
   end

   pasid_vcmd_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cap_on       (ALLOC_SUPPORTED),
      .cmd_wr       (cmd_wr),
      .cmd_val      (reg_wdata[27:0]),
      .accept       (accept),
      .rsp_q        (rsp_q),
      .scan_restart (scan_restart),
      .scan_step    (scan_step),
      .free_vld     (free_vld),
      .free_id      (free_id),
      .scan_hit     (scan_hit),
      .scan_last    (scan_last),
      .hit_id       (hit_id),
      .free_ok      (free_ok)
   );

   pasid_id_pool #(.NUM_IDS(NUM_IDS), .SCAN_LANES(SCAN_LANES)) u_pool (
      .clk          (clk),
      .rst_n        (rst_n),
      .scan_restart (scan_restart),
      .scan_step    (scan_step),
      .free_vld     (free_vld),
      .free_id      (free_id),
      .scan_hit     (scan_hit),
      .scan_last    (scan_last),
      .hit_id       (hit_id),
      .free_ok      (free_ok)
   );

   always_comb begin
      case (reg_addr)
         OFS_CAP:    reg_rdata = CAP_VAL;
         OFS_CMD_LO: reg_rdata = cmd_q;
         OFS_CMD_HI: reg_rdata = {32'd0, cmd_q[63:32]};
         OFS_RSP_LO: reg_rdata = rsp_q;
         OFS_RSP_HI: reg_rdata = {32'd0, rsp_q[63:32]};
         default:    reg_rdata = '0;
      endcase
   end

   // R10: a refused command write leaves the command register alone
   p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !accept) |=> $stable(cmd_q));
   // R13: a 32-bit low write keeps the upper half
   p_lo_keeps_hi_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && wr_lo && !reg_wide) |=> $stable(cmd_q[63:32]));
endmodule

// File: tb/pasid_vcmd_unit_tb.sv
module pasid_vcmd_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] reg_addr = 12'h0;
   logic        reg_wr = 1'b0;
   logic        reg_wide = 1'b0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata, nocap_rdata;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   pasid_vcmd_unit dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wide(reg_wide), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

   pasid_vcmd_unit #(.ALLOC_SUPPORTED(1'b0)) dut_nocap_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wide(reg_wide), .reg_wdata(reg_wdata), .reg_rdata(nocap_rdata));

   typedef struct packed {
      logic [11:0] addr;
      logic        wide;
      logic [63:0] data;
      logic [1:0]  st;
      logic [19:0] res;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{12'hE10, 1'b0, 64'h0,                    2'd0, 20'd0},  // R4 null
      '{12'hE10, 1'b0, 64'h1,                    2'd0, 20'd1},  // R5
      '{12'hE10, 1'b0, 64'h1,                    2'd0, 20'd2},  // R5
      '{12'hE10, 1'b0, 64'h1,                    2'd0, 20'd3},  // R5
      '{12'hE10, 1'b0, 64'h202,                  2'd0, 20'd0},  // R7 free 2
      '{12'hE10, 1'b0, 64'h1,                    2'd0, 20'd2},  // R7 reuse
      '{12'hE10, 1'b0, 64'h2,                    2'd2, 20'd0},  // R8 id 0
      '{12'hE10, 1'b0, 64'h4002,                 2'd2, 20'd0},  // R8 id 64
      '{12'hE10, 1'b0, 64'hA02,                  2'd2, 20'd0},  // R8 unused
      '{12'hE10, 1'b0, 64'h5,                    2'd1, 20'd0},  // R9
      '{12'hE10, 1'b0, 64'h012345FF,             2'd1, 20'd0},  // R9
      '{12'hE14, 1'b0, 64'h1,                    2'd0, 20'd4},  // R12
      '{12'hE10, 1'b1, 64'hABCD0000_00000001,    2'd0, 20'd5},  // R5 wide
      '{12'hE10, 1'b0, 64'hF0000302,             2'd0, 20'd0},  // R7 high bits
      '{12'hE10, 1'b0, 64'h1,                    2'd0, 20'd3}   // R7 reuse
   };

   function automatic logic [63:0] rsp_of(input logic [1:0] st, input logic [19:0] res);
      return {36'd0, res, 5'd0, st, 1'b0};
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic w, input logic [63:0] d);
      @(negedge clk);
      reg_addr = a; reg_wide = w; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [63:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_done(input string tag, output logic [63:0] r);
      for (int k = 0; k < 40; k++) begin
         bus_read(12'hE20, r);
         if (!r[0]) return;
         @(negedge clk);
      end
      check({tag, " busy timeout"}, r, 64'h0);
   endtask

   task automatic run_cmd(input string tag, input logic [11:0] a, input logic w,
                          input logic [63:0] d, input logic [1:0] st, input logic [19:0] res);
      logic [63:0] r;
      bus_write(a, w, d);
      bus_read(12'hE20, r);
      check("R3 busy after accept", r, 64'h1);
      wait_done(tag, r);
      check(tag, r, rsp_of(st, res));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [63:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      bus_read(12'hE20, r); check("R2 reset response", r, 64'h0);
      bus_read(12'hE10, r); check("R13 reset command", r, 64'h0);
      bus_read(12'hE00, r); check("R1 capability", r, 64'h1);

      for (int v = 0; v < NV; v++)
         run_cmd($sformatf("vector %0d", v), VECS[v].addr, VECS[v].wide,
                 VECS[v].data, VECS[v].st, VECS[v].res);

      // R5: fill the pool in ascending order
      for (int i = 6; i < 64; i++)
         run_cmd("R5 fill", 12'hE10, 1'b0, 64'h1, 2'd0, 20'(i));
      run_cmd("R6 exhausted", 12'hE10, 1'b0, 64'h1, 2'd2, 20'd0);

      // R1 / R2: writes to read-only registers
      bus_write(12'hE00, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE);
      bus_read(12'hE00, r); check("R1 capability write ignored", r, 64'h1);
      bus_write(12'hE20, 1'b1, 64'h0);
      bus_read(12'hE20, r); check("R2 response write ignored", r, rsp_of(2'd2, 20'd0));

      // R10: write during a long scan is dropped
      run_cmd("R7 free 63", 12'hE10, 1'b0, 64'h3F02, 2'd0, 20'd0);
      bus_write(12'hE10, 1'b0, 64'h1);
      bus_write(12'hE10, 1'b0, 64'h502);
      wait_done("R10", r);
      check("R10 scan result", r, rsp_of(2'd0, 20'd63));
      bus_read(12'hE10, r); check("R10 command unchanged", r, 64'hABCD0000_00000001);
      run_cmd("R10 free was dropped", 12'hE10, 1'b0, 64'h1, 2'd2, 20'd0);

      // R13 / R12: command register halves
      run_cmd("R13 wide null", 12'hE10, 1'b1, 64'h12345678_00000000, 2'd0, 20'd0);
      bus_read(12'hE10, r); check("R13 wide readback", r, 64'h12345678_00000000);
      run_cmd("R13 narrow null", 12'hE10, 1'b0, 64'hFFFFFFFF_00000100, 2'd0, 20'd0);
      bus_read(12'hE10, r); check("R13 narrow keeps upper", r, 64'h12345678_00000100);
      bus_read(12'hE14, r); check("R12 upper readback", r, 64'h12345678);

      // R11: instance without the capability
      bus_read(12'hE00, r); r = nocap_rdata; check("R11 capability clear", r, 64'h0);
      bus_read(12'hE10, r); r = nocap_rdata; check("R11 command untouched", r, 64'h0);
      bus_read(12'hE20, r); r = nocap_rdata; check("R11 response idle", r, 64'h0);

      // R14: reset empties the pool
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      bus_read(12'hE20, r); check("R14 response after reset", r, 64'h0);
      run_cmd("R14 first grant", 12'hE10, 1'b0, 64'h1, 2'd0, 20'd1);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule